// File: doc/BRIEF.md
# Sleep, Wake-up and Reset-Cause Controller

This block runs the power-down sequence of a small microcontroller core. A one-cycle sleep strobe from the core stops the oscillator, restarts the watchdog count and records in two status bits that the core went to sleep. While the core sleeps, the block waits for one of two kinds of event. A reset source (the external reset pin, a watchdog time-out, a power-on detect or the low-voltage detector) restarts the core from scratch. An enabled interrupt request wakes the core and lets it continue.

Every restart and every wake passes through a stabilisation delay. The delay has a fixed part, given in reference-clock ticks, followed by 128 oscillator cycles. A reset keeps the core in reset for the whole of this delay. An interrupt wake ends the delay with a one-cycle resume pulse. That pulse comes with a flag that tells the core whether to branch to the interrupt vector at 008h or to go on at the instruction after the sleep. The two status bits, PD and TO, let firmware tell the causes apart after a reset.

Top module: `pm_wake_ctrl`

## Requirements
- R1: A block reset (rst_n low) sets PD=1 and TO=1 and asserts core_rst_o with osc_en_o high. core_rst_o falls exactly FIX_TICKS+OSC_CYCLES+1 clock edges after the first edge at which rst_n is high.
- R2: A sleep strobe while the core runs, with no reset source present, makes PD=0, TO=1 and osc_en_o=0 after the next edge. wdt_clr_o goes high for exactly one cycle.
- R3: While asleep, an interrupt request whose enable bit is 0 has no effect: osc_en_o stays 0 and no resume pulse appears.
- R4: While asleep, a request with its enable bit set wakes the core whatever gie_i is. osc_en_o returns to 1 after the next edge, core_rst_o stays 0, PD and TO keep the values 0 and 1, and resume_o pulses at the (FIX_TICKS+OSC_CYCLES+1)-th edge, counting the edge that sampled the request as the first.
- R5: resume_o is high for one cycle. resume_isr_o equals the value gie_i had at the edge that sampled the wake: 1 selects the vector at 008h, 0 selects the next instruction.
- R6: The external reset pin during sleep asserts core_rst_o after the next edge and leaves PD=0 and TO=1. The core stays in reset while the pin is high and for FIX_TICKS+OSC_CYCLES+1 edges after it drops, and no resume pulse is issued.
- R7: A watchdog time-out, asleep or running, clears TO after the next edge, leaves PD unchanged and resets the core.
- R8: A power-on detect or low-voltage detect sets PD=1 and TO=1. core_rst_o stays high for as long as the detector is asserted.
- R9: An external pin reset while running leaves PD and TO unchanged.
- R10: osc_en_o is 0 only in the sleep state. It is 1 during reset hold and during the wake delay.
- R11: A reset source during the wake delay puts the core in reset and restarts the full delay once the source drops. The interrupted wake gives no resume pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Synchronous active-low block reset (power-up) |
| sleep_req_i | input | 1 | One-cycle strobe: the core executed a sleep instruction |
| irq_req_i | input | NIRQ | Interrupt wake requests |
| irq_en_i | input | NIRQ | Per-request wake enables |
| gie_i | input | 1 | Global interrupt enable of the core |
| por_det_i | input | 1 | Power-on detect |
| lvd_det_i | input | 1 | Low-voltage detect (brown-out) |
| ext_rst_i | input | 1 | External reset pin, active high, already synchronised |
| wdt_tmo_i | input | 1 | Watchdog time-out |
| osc_en_o | output | 1 | Oscillator driver enable |
| wdt_clr_o | output | 1 | One-cycle watchdog counter clear |
| core_rst_o | output | 1 | Core reset, active high |
| pd_o | output | 1 | Power-down status bit |
| to_o | output | 1 | Time-out status bit |
| resume_o | output | 1 | One-cycle pulse: core may continue after an interrupt wake |
| resume_isr_o | output | 1 | With resume_o: 1 branch to 008h, 0 next instruction |

## Verification
Embedded properties watch the cause bits on every cycle. Each detector reset must leave PD and TO set, each time-out must clear TO, a pin reset while running must leave both bits alone, and a sleep entry must give PD=0 with TO=1. The same properties require a wake request or reset in sleep to reach the right output the next cycle, and they keep the resume pulse and vector flag single and clear of core reset. The exact length of the stabilisation delay, the gie-dependent vector choice, the disregard of disabled requests, and the restart of the delay when a reset interrupts it span many cycles. Only the bench's directed scenarios show these.

// File: rtl/pm_wake_pkg.sv
`timescale 1ns/1ps
// Shared types for the sleep / wake / reset-cause controller.
// Assumes: consumers import the package; no state lives here.
package pm_wake_pkg;

    // Controller states; RST_HOLD is also the power-up state.
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SLEEP    = 2'd1,
        ST_WAKE_DLY = 2'd2,
        ST_RST_HOLD = 2'd3
    } pm_state_e;

    // Reset sources seen by the controller.
    typedef struct packed {
        logic por;
        logic lvd;
        logic pin;
        logic wdt;
    } rst_src_t;

endpackage

// File: rtl/pm_wake_detect.sv
`timescale 1ns/1ps
// Combines interrupt wake requests with their enables.
// Assumes: requests are level signals synchronous to clk.
module pm_wake_detect #(
    parameter int NIRQ = 2
) (
    input  logic [NIRQ-1:0] req_i,
    input  logic [NIRQ-1:0] en_i,
    output logic            wake_any_o
);

    logic [NIRQ-1:0] hit;

    // One gate per request line: a request only counts when enabled.
    for (genvar g = 0; g < NIRQ; g++) begin : g_hit
        assign hit[g] = req_i[g] & en_i[g];
    end

    // Any enabled request wakes the core.
    assign wake_any_o = |hit;

endmodule

// File: rtl/pm_delay_timer.sv
`timescale 1ns/1ps
// Two-phase stabilisation timer: FIX_TICKS cycles, then OSC_CYCLES cycles.
// Assumes: run_i stays high for the whole delay; dropping it clears the timer.
// done_o is high in the last cycle, so a run lasts FIX_TICKS+OSC_CYCLES cycles.
module pm_delay_timer #(
    parameter int FIX_TICKS  = 576,
    parameter int OSC_CYCLES = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic done_o
);

    localparam int FW = (FIX_TICKS  > 1) ? $clog2(FIX_TICKS)  : 1;
    localparam int OW = (OSC_CYCLES > 1) ? $clog2(OSC_CYCLES) : 1;
    localparam logic [FW-1:0] FIX_LAST = FW'(FIX_TICKS - 1);
    localparam logic [OW-1:0] OSC_LAST = OW'(OSC_CYCLES - 1);

    logic [FW-1:0] fix_cnt;
    logic [OW-1:0] osc_cnt;
    logic          in_osc;

    // Count the fixed part, then the oscillator part; clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            fix_cnt <= '0;
            osc_cnt <= '0;
            in_osc  <= 1'b0;
        end else if (!in_osc) begin
            if (fix_cnt == FIX_LAST) begin
                in_osc  <= 1'b1;
                fix_cnt <= '0;
            end else begin
                fix_cnt <= fix_cnt + 1'b1;
            end
        end else if (osc_cnt != OSC_LAST) begin
            osc_cnt <= osc_cnt + 1'b1;
        end
    end

    // Last cycle of the oscillator phase.
    assign done_o = run_i && in_osc && (osc_cnt == OSC_LAST);

    // R11: a freshly started delay never finishes in its first cycle.
    a_r11_fresh_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> !done_o);

endmodule

// File: rtl/pm_cause_reg.sv
`timescale 1ns/1ps
// Holds the PD (power-down) and TO (time-out) reset-cause bits.
// Priority: detector reset > watchdog time-out > sleep entry.
// Assumes: sleep_ent_i is only high when no reset source is present.
module pm_cause_reg (
    input  logic clk,
    input  logic rst_n,
    input  logic por_lvd_i,
    input  logic wdt_tmo_i,
    input  logic sleep_ent_i,
    output logic pd_o,
    output logic to_o
);

    // Update the cause bits by source priority.
    always_ff @(posedge clk) begin
        if (!rst_n || por_lvd_i) begin
            pd_o <= 1'b1;
            to_o <= 1'b1;
        end else if (wdt_tmo_i) begin
            to_o <= 1'b0;
        end else if (sleep_ent_i) begin
            pd_o <= 1'b0;
            to_o <= 1'b1;
        end
    end

    // R8: detector resets set both bits.
    a_r8_detect_sets: assert property (@(posedge clk) disable iff (!rst_n)
        por_lvd_i |=> (pd_o && to_o));
    // R7: a time-out clears TO and keeps PD.
    a_r7_tmo_clears_to: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_tmo_i && !por_lvd_i) |=> (!to_o && $stable(pd_o)));
    // R2: sleep entry gives PD=0, TO=1.
    a_r2_sleep_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_ent_i && !por_lvd_i && !wdt_tmo_i) |=> (!pd_o && to_o));

endmodule

// File: rtl/pm_wake_fsm.sv
`timescale 1ns/1ps
// Power state machine: RUN, SLEEP, WAKE_DLY and RST_HOLD.
// A reset source in any state goes to RST_HOLD; an enabled wake in SLEEP
// goes to WAKE_DLY. The wake delay after a reset keeps the core in reset.
// Assumes: rst_any_i and wake_any_i are synchronous to clk.
module pm_wake_fsm
    import pm_wake_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req_i,
    input  logic      wake_any_i,
    input  logic      gie_i,
    input  logic      rst_any_i,
    input  logic      dly_done_i,
    output pm_state_e state_o,
    output logic      sleep_ent_o,
    output logic      dly_run_o,
    output logic      core_rst_o,
    output logic      osc_en_o,
    output logic      wdt_clr_o,
    output logic      resume_o,
    output logic      resume_isr_o
);

    pm_state_e state, nxt;
    logic      from_rst;
    logic      gie_cap;
    logic      wake_go;
    logic      dly_end;

    assign sleep_ent_o = (state == ST_RUN) && sleep_req_i && !rst_any_i;
    assign wake_go     = (state == ST_SLEEP) && wake_any_i && !rst_any_i;
    assign dly_end     = (state == ST_WAKE_DLY) && dly_done_i && !rst_any_i;

    // Next-state choice; reset sources take priority in every state.
    always_comb begin
        nxt = state;
        if (rst_any_i) begin
            nxt = ST_RST_HOLD;
        end else begin
            unique case (state)
                ST_RUN:      if (sleep_req_i) nxt = ST_SLEEP;
                ST_SLEEP:    if (wake_any_i)  nxt = ST_WAKE_DLY;
                ST_WAKE_DLY: if (dly_done_i)  nxt = ST_RUN;
                ST_RST_HOLD: nxt = ST_WAKE_DLY;
                default:     nxt = ST_RST_HOLD;
            endcase
        end
    end

    // State register; power-up starts in reset hold.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RST_HOLD;
        else        state <= nxt;
    end

    // Remember whether the pending delay follows a reset or a wake.
    always_ff @(posedge clk) begin
        if (!rst_n || rst_any_i) from_rst <= 1'b1;
        else if (wake_go)        from_rst <= 1'b0;
    end

    // Capture the global enable at the wake event.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_cap <= 1'b0;
        else if (wake_go) gie_cap <= gie_i;
    end

    // Registered one-cycle pulses: watchdog clear and resume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wdt_clr_o    <= 1'b0;
            resume_o     <= 1'b0;
            resume_isr_o <= 1'b0;
        end else begin
            wdt_clr_o    <= sleep_ent_o;
            resume_o     <= dly_end && !from_rst;
            resume_isr_o <= dly_end && !from_rst && gie_cap;
        end
    end

    assign state_o    = state;
    assign dly_run_o  = (state == ST_WAKE_DLY);
    assign core_rst_o = (state == ST_RST_HOLD) || ((state == ST_WAKE_DLY) && from_rst);
    assign osc_en_o   = (state != ST_SLEEP);

    // R5: the vector flag only comes with the resume pulse.
    a_r5_isr_with_resume: assert property (@(posedge clk) disable iff (!rst_n)
        resume_isr_o |-> resume_o);
    // R5: resume is a single-cycle pulse.
    a_r5_resume_single: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |=> !resume_o);
    // R6: no resume while the core is held in reset.
    a_r6_no_resume_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
        resume_o |-> !core_rst_o);
    // R6: a reset source while asleep resets the core.
    a_r6_rst_in_sleep: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_SLEEP) && rst_any_i) |=> core_rst_o);
    // R2: watchdog clear lasts one cycle.
    a_r2_wdt_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_clr_o |=> !wdt_clr_o);
    // R10: the oscillator only stops after a sleep strobe.
    a_r10_osc_off_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(osc_en_o) |-> $past(sleep_req_i));
    // R4: an enabled wake restarts the oscillator without a core reset.
    a_r4_irq_wakes: assert property (@(posedge clk) disable iff (!rst_n)
        wake_go |=> (osc_en_o && !core_rst_o));

endmodule

// File: rtl/pm_wake_ctrl.sv
`timescale 1ns/1ps
// Top of the sleep / wake-up / reset-cause controller.
// Gathers reset sources, combines interrupt wakes, and connects the state
// machine, the stabilisation timer and the cause bits.
// Assumes: all inputs are synchronous to the always-on clk.
module pm_wake_ctrl
    import pm_wake_pkg::*;
#(
    parameter int NIRQ       = 2,
    parameter int FIX_TICKS  = 576,
    parameter int OSC_CYCLES = 128
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sleep_req_i,
    input  logic [NIRQ-1:0] irq_req_i,
    input  logic [NIRQ-1:0] irq_en_i,
    input  logic            gie_i,
    input  logic            por_det_i,
    input  logic            lvd_det_i,
    input  logic            ext_rst_i,
    input  logic            wdt_tmo_i,
    output logic            osc_en_o,
    output logic            wdt_clr_o,
    output logic            core_rst_o,
    output logic            pd_o,
    output logic            to_o,
    output logic            resume_o,
    output logic            resume_isr_o
);

    rst_src_t  src;
    logic      rst_any;
    logic      wake_any;
    logic      sleep_ent;
    logic      dly_run;
    logic      dly_done;
    pm_state_e state;

    // Collect reset sources.
    assign src     = '{por: por_det_i, lvd: lvd_det_i, pin: ext_rst_i, wdt: wdt_tmo_i};
    assign rst_any = |src;

    pm_wake_detect #(.NIRQ(NIRQ)) u_detect (
        .req_i      (irq_req_i),
        .en_i       (irq_en_i),
        .wake_any_o (wake_any)
    );

    pm_wake_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sleep_req_i  (sleep_req_i),
        .wake_any_i   (wake_any),
        .gie_i        (gie_i),
        .rst_any_i    (rst_any),
        .dly_done_i   (dly_done),
        .state_o      (state),
        .sleep_ent_o  (sleep_ent),
        .dly_run_o    (dly_run),
        .core_rst_o   (core_rst_o),
        .osc_en_o     (osc_en_o),
        .wdt_clr_o    (wdt_clr_o),
        .resume_o     (resume_o),
        .resume_isr_o (resume_isr_o)
    );

    pm_delay_timer #(.FIX_TICKS(FIX_TICKS), .OSC_CYCLES(OSC_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (dly_run),
        .done_o (dly_done)
    );

    pm_cause_reg u_cause (
        .clk         (clk),
        .rst_n       (rst_n),
        .por_lvd_i   (src.por | src.lvd),
        .wdt_tmo_i   (src.wdt),
        .sleep_ent_i (sleep_ent),
        .pd_o        (pd_o),
        .to_o        (to_o)
    );

    // R9: a pin-only reset leaves the cause bits alone.
    a_r9_pin_keeps_cause: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_rst_i && !por_det_i && !lvd_det_i && !wdt_tmo_i) |=> ($stable(pd_o) && $stable(to_o)));
    // R8: detector resets hold the core in reset.
    a_r8_detect_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (por_det_i || lvd_det_i) |=> core_rst_o);
    // R11: reset during the wake delay puts the core in reset.
    a_r11_rst_in_delay: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_WAKE_DLY) && rst_any) |=> core_rst_o);

endmodule

// File: tb/test_pm_wake_ctrl.sv
`timescale 1ns/1ps
// Directed bench for pm_wake_ctrl: one task per scenario.
module test_pm_wake_ctrl;

    localparam int NIRQ  = 2;
    localparam int FIX   = 40;
    localparam int OSC   = 128;
    localparam int TOTAL = FIX + OSC;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            sleep_req = 1'b0;
    logic [NIRQ-1:0] irq_req = '0;
    logic [NIRQ-1:0] irq_en = '0;
    logic            gie = 1'b0;
    logic            por_det = 1'b0;
    logic            lvd_det = 1'b0;
    logic            ext_rst = 1'b0;
    logic            wdt_tmo = 1'b0;
    logic            osc_en, wdt_clr, core_rst, pd, to_b, resume, resume_isr;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    pm_wake_ctrl #(.NIRQ(NIRQ), .FIX_TICKS(FIX), .OSC_CYCLES(OSC)) i_pm_wake_ctrl (
        .clk(clk), .rst_n(rst_n), .sleep_req_i(sleep_req), .irq_req_i(irq_req),
        .irq_en_i(irq_en), .gie_i(gie), .por_det_i(por_det), .lvd_det_i(lvd_det),
        .ext_rst_i(ext_rst), .wdt_tmo_i(wdt_tmo), .osc_en_o(osc_en),
        .wdt_clr_o(wdt_clr), .core_rst_o(core_rst), .pd_o(pd), .to_o(to_b),
        .resume_o(resume), .resume_isr_o(resume_isr)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Sources already low: count edges until core reset falls; watch for resume.
    task automatic wait_release(input string req);
        int n = 0;
        int saw_resume = 0;
        while (n < TOTAL + 20) begin
            @(negedge clk);
            n++;
            if (resume) saw_resume = 1;
            if (!core_rst) break;
        end
        check({req, " release edges"}, n, TOTAL + 1);
        check({req, " no resume"}, saw_resume, 0);
    endtask

    // Sleep strobe for one cycle; checks R2 on the next cycle.
    task automatic enter_sleep();
        @(negedge clk);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
        check("R2 osc off", osc_en, 0);
        check("R2 pd", pd, 0);
        check("R2 to", to_b, 1);
        check("R2 wdt_clr", wdt_clr, 1);
        @(negedge clk);
        check("R2 wdt_clr single", wdt_clr, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 core_rst", core_rst, 1);
        check("R1 pd", pd, 1);
        check("R1 to", to_b, 1);
        check("R10 osc in reset", osc_en, 1);
        rst_n = 1'b1;
        wait_release("R1");
    endtask

    // R3: stays asleep; a disabled request is ignored.
    task automatic t_stay_asleep();
        int res = 0;
        enter_sleep();
        irq_req = 2'b01;
        irq_en  = 2'b10;
        repeat (12) begin
            @(negedge clk);
            if (resume) res = 1;
        end
        check("R3 osc stays off", osc_en, 0);
        check("R3 no resume", res, 0);
        irq_req = '0;
    endtask

    // R4/R5: enabled wake with a given gie.
    task automatic t_wake(input logic g);
        int n = 0;
        int saw_rst = 0;
        irq_en = 2'b11;
        gie = g;
        @(negedge clk);
        irq_req = 2'b10;
        while (n < TOTAL + 20) begin
            @(negedge clk);
            n++;
            if (n == 1) begin
                check("R4 osc on after wake", osc_en, 1);
                irq_req = '0;
                gie = ~g;
            end
            if (core_rst) saw_rst = 1;
            if (resume) break;
        end
        check("R4 resume edges", n, TOTAL + 1);
        check("R4 no core reset", saw_rst, 0);
        check("R4 pd", pd, 0);
        check("R4 to", to_b, 1);
        check("R5 vector select", resume_isr, g);
        @(negedge clk);
        check("R5 resume single", resume, 0);
        irq_en = '0;
        gie = 1'b0;
    endtask

    task automatic t_pin_in_sleep();
        enter_sleep();
        ext_rst = 1'b1;
        @(negedge clk);
        check("R6 core_rst", core_rst, 1);
        check("R10 osc on in reset", osc_en, 1);
        @(negedge clk);
        check("R6 pd kept", pd, 0);
        check("R6 to kept", to_b, 1);
        ext_rst = 1'b0;
        wait_release("R6");
    endtask

    task automatic t_wdt(input string req, input int exp_pd);
        wdt_tmo = 1'b1;
        @(negedge clk);
        wdt_tmo = 1'b0;
        check({req, " core_rst"}, core_rst, 1);
        check({req, " to cleared"}, to_b, 0);
        check({req, " pd kept"}, pd, exp_pd);
        wait_release(req);
    endtask

    task automatic t_lvd();
        @(negedge clk);
        lvd_det = 1'b1;
        repeat (6) @(negedge clk);
        check("R8 held in reset", core_rst, 1);
        check("R8 pd", pd, 1);
        check("R8 to", to_b, 1);
        lvd_det = 1'b0;
        wait_release("R8");
    endtask

    task automatic t_pin_in_run();
        @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        check("R9 core_rst", core_rst, 1);
        check("R9 pd", pd, 1);
        check("R9 to", to_b, 0);
        wait_release("R9");
    endtask

    task automatic t_rst_in_delay();
        enter_sleep();
        irq_en = 2'b01;
        irq_req = 2'b01;
        @(negedge clk);
        irq_req = '0;
        repeat (50) @(negedge clk);
        ext_rst = 1'b1;
        @(negedge clk);
        ext_rst = 1'b0;
        check("R11 core_rst", core_rst, 1);
        wait_release("R11");
        irq_en = '0;
    endtask

    initial begin
        t_reset();
        t_stay_asleep();
        t_wake(1'b0);
        enter_sleep();
        t_wake(1'b1);
        t_pin_in_sleep();
        enter_sleep();
        t_wdt("R7 sleep", 0);
        t_lvd();
        t_wdt("R7 run", 1);
        t_pin_in_run();
        t_rst_in_delay();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule